// File: doc/BRIEF.md
# History Buffer Precise-Exception Unit

This unit gives an out-of-order core precise exceptions even though every result goes straight into the architectural register file when the instruction completes. At issue, each instruction takes a slot in a 16-entry circular buffer in program order. The slot holds the destination register and the value that register held before the instruction. Completions may arrive in any order. Each one writes the register file at once, and a slot leaves the buffer from the head once it has completed cleanly.

When the slot at the head is marked as excepting, the unit blocks issue in that same cycle. It then waits until every slot in the buffer has completed. After that it walks from the youngest slot back to the excepting one, one slot per cycle, and writes each saved value back into its register. It pulses a done strobe when the walk ends, and the buffer is then empty.

Several in-flight instructions may name the same destination, and issue never stalls for this. Two rules keep the result correct:
- A completing result is copied into the saved-value field of the nearest younger slot with the same destination.
- The register file write is dropped when a younger slot with that destination has already completed.

Top module: `hbuf_unit`

## Requirements
- R1: An accepted issue (issueValid high while issueReady is high) allocates the slot shown on issueTag. issueTag advances by one modulo 16 per accepted issue. The slot saves the destination register's value as it is at issue time.
- R2: A clean completion (cmplExc low) writes cmplData into the destination register of slot cmplTag. The write is visible on rdData one cycle later, including while the unit is draining.
- R3: A completion does not change the register file when a younger in-flight slot with the same destination has already completed. The register keeps the youngest completed result.
- R4: retireValid is high in a cycle exactly when the head slot has completed without an exception and the unit is not halted. The head slot is then removed at that clock edge. A younger completed slot never retires ahead of an incomplete head.
- R5: An exception is acted on only when its slot is at the head. issueReady drops in the same cycle the excepting slot is at the head, and halted rises one cycle later. An exception in a slot that is not at the head leaves issueReady and halted unchanged.
- R6: While halted, no restore takes place until every slot in the buffer has completed. restoreDone stays low and the registers keep their values during the wait.
- R7: After the wait, the unit restores saved values from the youngest slot back to the excepting slot, one per cycle. It then pulses restoreDone for one cycle with halted low. The buffer is then empty, issueTag equals the excepting slot's index, and every register holds the value it had just before the excepting instruction.
- R8: With 16 slots occupied, issueReady is low. An issue attempted then is ignored and issueTag does not move.
- R9: After reset, issueReady is high, halted, retireValid and restoreDone are low, issueTag is 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request for one instruction |
| issueDest | input | 5 | Destination register of the issuing instruction |
| issueReady | output | 1 | Issue is accepted this cycle |
| issueTag | output | 4 | Slot index given to the issuing instruction |
| cmplValid | input | 1 | A completion is presented |
| cmplTag | input | 4 | Slot index of the completing instruction |
| cmplData | input | 32 | Result of the completing instruction |
| cmplExc | input | 1 | The completing instruction raised an exception |
| rdAddr | input | 5 | Register file read address |
| rdData | output | 32 | Register file read data |
| retireValid | output | 1 | The head slot retires at this edge |
| halted | output | 1 | Exception handling is in progress |
| restoreDone | output | 1 | One-cycle pulse at the end of the rollback walk |

## Verification
The assertions check on every cycle that occupancy stays within 16 and that a full or halted unit refuses issue. They also check that retirement never overlaps a halt, that occupancy follows issue and retirement exactly, and that the done pulse lasts a single cycle and leaves an empty buffer. The values in the register file can be judged only by the bench's scenarios, which count cycles and predict each value:
- the write-after-write case, where an older result arrives late;
- the forwarding of a late older result into a younger slot's saved value;
- the final register contents after a rollback over several writers of one register;
- the wait for outstanding completions before a restore begins.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  typedef struct packed {
    logic alloc;    // write a new slot at the tail
    logic retire;   // drop the head slot
    logic restore;  // replay the slot under the cursor
  } hbStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_ROLL  = 2'd2
  } hbState_t;
endpackage

// File: rtl/hbuf_ctrl.sv
module hbuf_ctrl
  import hbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic            headValid,
  input  logic            headDone,
  input  logic            headExc,
  input  logic            allDone,
  output hbStrobe_t       strb,
  output logic [PTRW-1:0] tailIdx,
  output logic [PTRW-1:0] headIdx,
  output logic [PTRW-1:0] cursorIdx,
  output logic [CNTW-1:0] entryCount,
  output logic            issueReady,
  output logic            retireValid,
  output logic            halted,
  output logic            restoreDone
);
  hbState_t        stateQ;
  logic [PTRW-1:0] headQ, tailQ, cursorQ;
  logic [CNTW-1:0] countQ, countD;
  logic            doneQ;
  logic            full, excAtHead, lastRestore;

  assign full        = (countQ == CNTW'(DEPTH));
  assign excAtHead   = headValid & headDone & headExc;
  assign issueReady  = (stateQ == ST_RUN) & ~full & ~excAtHead;

  assign strb.alloc   = issueValid & issueReady;
  assign strb.retire  = (stateQ == ST_RUN) & headValid & headDone & ~headExc;
  assign strb.restore = (stateQ == ST_ROLL);
  assign lastRestore  = strb.restore & (cursorQ == headQ);

  assign countD = countQ + CNTW'(strb.alloc) - CNTW'(strb.retire) - CNTW'(strb.restore);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_RUN;
      headQ   <= '0;
      tailQ   <= '0;
      cursorQ <= '0;
      countQ  <= '0;
      doneQ   <= 1'b0;
    end else begin
      countQ <= countD;
      doneQ  <= lastRestore;
      if (strb.retire)  headQ <= headQ + PTRW'(1);
      if (strb.alloc)   tailQ <= tailQ + PTRW'(1);
      if (strb.restore) tailQ <= cursorQ;
      unique case (stateQ)
        ST_RUN: begin
          if (excAtHead) stateQ <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (allDone) begin
            stateQ  <= ST_ROLL;
            cursorQ <= tailQ - PTRW'(1);
          end
        end
        ST_ROLL: begin
          cursorQ <= cursorQ - PTRW'(1);
          if (lastRestore) stateQ <= ST_RUN;
        end
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  assign tailIdx     = tailQ;
  assign headIdx     = headQ;
  assign cursorIdx   = cursorQ;
  assign entryCount  = countQ;
  assign retireValid = strb.retire;
  assign halted      = (stateQ != ST_RUN);
  assign restoreDone = doneQ;
endmodule

// File: rtl/hbuf_data.sv
module hbuf_data
  import hbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  localparam int PTRW = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  hbStrobe_t       strb,
  input  logic [PTRW-1:0] allocIdx,
  input  logic [PTRW-1:0] headIdx,
  input  logic [PTRW-1:0] restoreIdx,
  input  logic [RW-1:0]   issueDest,
  input  logic            cmplValid,
  input  logic [PTRW-1:0] cmplTag,
  input  logic [XLEN-1:0] cmplData,
  input  logic            cmplExc,
  input  logic [RW-1:0]   rdAddr,
  output logic [XLEN-1:0] rdData,
  output logic            headValid,
  output logic            headDone,
  output logic            headExc,
  output logic            allDone
);
  logic [DEPTH-1:0] validQ, doneQ, excQ;
  logic [RW-1:0]    destQ [DEPTH];
  logic [XLEN-1:0]  oldQ  [DEPTH];
  logic [XLEN-1:0]  rfQ   [NREG];

  logic [RW-1:0]    cmplDest;
  logic             cmplLive, fwdHit, youngerDone, rfWe;
  logic [PTRW-1:0]  fwdIdx, scanIdx, ageT, ageI;
  logic [XLEN-1:0]  capVal;

  assign cmplDest = destQ[cmplTag];
  assign cmplLive = cmplValid & validQ[cmplTag] & ~doneQ[cmplTag];

  // Scan younger slots in age order: first same-destination hit gets the forward.
  always_comb begin
    fwdHit      = 1'b0;
    fwdIdx      = '0;
    youngerDone = 1'b0;
    scanIdx     = '0;
    ageI        = '0;
    ageT        = cmplTag - headIdx;
    for (int k = 1; k < DEPTH; k++) begin
      scanIdx = cmplTag + PTRW'(k);
      ageI    = scanIdx - headIdx;
      if (validQ[scanIdx] && (ageI > ageT) && (destQ[scanIdx] == cmplDest)) begin
        if (!fwdHit) begin
          fwdHit = 1'b1;
          fwdIdx = scanIdx;
        end
        if (doneQ[scanIdx]) youngerDone = 1'b1;
      end
    end
  end

  assign rfWe   = cmplLive & ~cmplExc & ~youngerDone;
  assign capVal = (cmplLive && !cmplExc && !fwdHit && (cmplDest == issueDest))
                  ? cmplData : rfQ[issueDest];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      doneQ  <= '0;
      excQ   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        destQ[i] <= '0;
        oldQ[i]  <= '0;
      end
    end else begin
      if (strb.alloc) begin
        validQ[allocIdx] <= 1'b1;
        doneQ[allocIdx]  <= 1'b0;
        excQ[allocIdx]   <= 1'b0;
        destQ[allocIdx]  <= issueDest;
        oldQ[allocIdx]   <= capVal;
      end
      if (cmplLive) begin
        doneQ[cmplTag] <= 1'b1;
        excQ[cmplTag]  <= cmplExc;
        if (fwdHit && !cmplExc) oldQ[fwdIdx] <= cmplData;
      end
      if (strb.retire)  validQ[headIdx]    <= 1'b0;
      if (strb.restore) validQ[restoreIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) rfQ[r] <= '0;
    end else if (strb.restore) begin
      rfQ[destQ[restoreIdx]] <= oldQ[restoreIdx];
    end else if (rfWe) begin
      rfQ[cmplDest] <= cmplData;
    end
  end

  assign rdData    = rfQ[rdAddr];
  assign headValid = validQ[headIdx];
  assign headDone  = doneQ[headIdx];
  assign headExc   = excQ[headIdx];
  assign allDone   = &(~validQ | doneQ);
endmodule

// File: rtl/hbuf_unit.sv
module hbuf_unit
  import hbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  localparam int PTRW = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic [RW-1:0]   issueDest,
  output logic            issueReady,
  output logic [PTRW-1:0] issueTag,
  input  logic            cmplValid,
  input  logic [PTRW-1:0] cmplTag,
  input  logic [XLEN-1:0] cmplData,
  input  logic            cmplExc,
  input  logic [RW-1:0]   rdAddr,
  output logic [XLEN-1:0] rdData,
  output logic            retireValid,
  output logic            halted,
  output logic            restoreDone
);
  hbStrobe_t       strb;
  logic [PTRW-1:0] tailIdx, headIdx, cursorIdx;
  logic [CNTW-1:0] entryCount;
  logic            headValid, headDone, headExc, allDone;

  hbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .headValid(headValid), .headDone(headDone), .headExc(headExc), .allDone(allDone),
    .strb(strb), .tailIdx(tailIdx), .headIdx(headIdx), .cursorIdx(cursorIdx),
    .entryCount(entryCount), .issueReady(issueReady), .retireValid(retireValid),
    .halted(halted), .restoreDone(restoreDone)
  );

  hbuf_data #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocIdx(tailIdx), .headIdx(headIdx), .restoreIdx(cursorIdx),
    .issueDest(issueDest), .cmplValid(cmplValid), .cmplTag(cmplTag),
    .cmplData(cmplData), .cmplExc(cmplExc), .rdAddr(rdAddr), .rdData(rdData),
    .headValid(headValid), .headDone(headDone), .headExc(headExc), .allDone(allDone)
  );

  assign issueTag = tailIdx;
endmodule

// File: rtl/hbuf_chk.sv
module hbuf_chk #(
  parameter int DEPTH = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            issueValid,
  input logic            issueReady,
  input logic            retireValid,
  input logic            halted,
  input logic            restoreDone,
  input logic [CNTW-1:0] entryCount
);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= CNTW'(DEPTH));

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryCount == CNTW'(DEPTH)) |-> !issueReady);

  // R5
  halt_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !issueReady);

  // R4
  retire_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |-> !halted);

  // R1
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady) |=>
      entryCount == CNTW'($past(entryCount) + CNTW'(1) - CNTW'($past(retireValid))));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    restoreDone |=> !restoreDone);

  // R7
  done_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    restoreDone |-> (entryCount == '0) && !halted);
endmodule

bind hbuf_unit hbuf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .retireValid(retireValid), .halted(halted), .restoreDone(restoreDone),
  .entryCount(entryCount)
);

// File: tb/hbuf_unit_tb_top.sv
`timescale 1ns/1ps
module hbuf_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [4:0]  issueDest = '0;
  logic        issueReady;
  logic [3:0]  issueTag;
  logic        cmplValid = 1'b0;
  logic [3:0]  cmplTag = '0;
  logic [31:0] cmplData = '0;
  logic        cmplExc = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        retireValid, halted, restoreDone;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  hbuf_unit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueDest(issueDest),
    .issueReady(issueReady), .issueTag(issueTag), .cmplValid(cmplValid),
    .cmplTag(cmplTag), .cmplData(cmplData), .cmplExc(cmplExc), .rdAddr(rdAddr),
    .rdData(rdData), .retireValid(retireValid), .halted(halted), .restoreDone(restoreDone)
  );

  // {dest, result}: issue, complete cleanly, read back, retire
  localparam logic [36:0] VEC [6] = '{
    {5'd3,  32'h0000_0011},
    {5'd7,  32'hAAAA_5555},
    {5'd5,  32'h0000_0055},
    {5'd31, 32'hFFFF_FFFF},
    {5'd5,  32'h0000_0100},
    {5'd0,  32'h0000_1234}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrapUp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doIssue(input logic [4:0] d, output logic [3:0] tag);
    tag = issueTag;
    issueValid = 1'b1;
    issueDest  = d;
    tick();
    issueValid = 1'b0;
  endtask

  task automatic doComplete(input logic [3:0] t, input logic [31:0] v, input logic e);
    cmplValid = 1'b1;
    cmplTag   = t;
    cmplData  = v;
    cmplExc   = e;
    tick();
    cmplValid = 1'b0;
    cmplExc   = 1'b0;
  endtask

  function automatic logic [31:0] readReg(input logic [4:0] a);
    rdAddr = a;
    return dut_i.rdData;
  endfunction

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.1;
    v = rdData;
  endtask

  task automatic waitDone(output logic sawHalt);
    sawHalt = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (halted) sawHalt = 1'b1;
      if (restoreDone) break;
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrapUp();
  end

  initial begin
    logic [3:0]  expTag;
    logic [3:0]  tg, t1, t2, t3, k1, k2, k3;
    logic [3:0]  fullTags [16];
    logic [31:0] v;
    logic        sawHalt;

    repeat (3) tick();
    rstN = 1'b1;
    #1;

    // R9: reset state
    check("R9 issueReady", 32'(issueReady), 32'd1);
    check("R9 halted", 32'(halted), 32'd0);
    check("R9 retireValid", 32'(retireValid), 32'd0);
    check("R9 issueTag", 32'(issueTag), 32'd0);
    peek(5'd5, v);
    check("R9 reg5 zero", v, 32'd0);

    // R1 R2 R4: table of clean single instructions
    expTag = 4'd0;
    for (int i = 0; i < 6; i++) begin
      doIssue(VEC[i][36:32], tg);
      check("R1 tag", 32'(tg), 32'(expTag));
      expTag = expTag + 4'd1;
      doComplete(tg, VEC[i][31:0], 1'b0);
      peek(VEC[i][36:32], v);
      check("R2 result visible", v, VEC[i][31:0]);
      check("R4 head retires", 32'(retireValid), 32'd1);
      tick();
    end

    // R3 R5 R7: three writers of r5, third completes first, second excepts
    doIssue(5'd5, t1);
    doIssue(5'd5, t2);
    doIssue(5'd5, t3);
    doComplete(t3, 32'h0000_0333, 1'b0);
    peek(5'd5, v);
    check("R2 young result", v, 32'h0000_0333);
    check("R4 no retire past open head", 32'(retireValid), 32'd0);
    doComplete(t1, 32'h0000_0111, 1'b0);
    peek(5'd5, v);
    check("R3 late older ignored", v, 32'h0000_0333);
    check("R4 head done retires", 32'(retireValid), 32'd1);
    doComplete(t2, 32'h0000_DEAD, 1'b1);
    check("R5 issue blocked at once", 32'(issueReady), 32'd0);
    check("R5 halted lags one cycle", 32'(halted), 32'd0);
    tick();
    check("R5 halted", 32'(halted), 32'd1);
    waitDone(sawHalt);
    check("R7 restoreDone", 32'(restoreDone), 32'd1);
    peek(5'd5, v);
    check("R7 reg5 back to first result", v, 32'h0000_0111);
    check("R7 halted cleared", 32'(halted), 32'd0);
    check("R7 tail at excepting slot", 32'(issueTag), 32'(t2));
    tick();
    check("R7 pulse one cycle", 32'(restoreDone), 32'd0);

    // R5 R6: exception not at head, then drain waits on an open slot
    doIssue(5'd10, k1);
    doIssue(5'd11, k2);
    doIssue(5'd11, k3);
    doComplete(k2, 32'h0000_0BAD, 1'b1);
    repeat (3) tick();
    check("R5 non-head exception no halt", 32'(halted), 32'd0);
    check("R5 non-head exception issue open", 32'(issueReady), 32'd1);
    doComplete(k1, 32'h0000_0010, 1'b0);
    repeat (4) tick();
    check("R6 halted while open", 32'(halted), 32'd1);
    check("R6 no restore yet", 32'(restoreDone), 32'd0);
    peek(5'd11, v);
    check("R6 reg11 untouched", v, 32'd0);
    doComplete(k3, 32'h0000_0777, 1'b0);
    peek(5'd11, v);
    check("R2 write during drain", v, 32'h0000_0777);
    waitDone(sawHalt);
    check("R7 restoreDone after drain", 32'(restoreDone), 32'd1);
    peek(5'd11, v);
    check("R7 reg11 restored", v, 32'd0);
    peek(5'd10, v);
    check("R7 retired reg10 kept", v, 32'h0000_0010);
    check("R7 tail at excepting slot", 32'(issueTag), 32'(k2));

    // R8 R3: fill all 16 slots on r20, complete youngest first
    tick();
    for (int i = 0; i < 16; i++) begin
      doIssue(5'd20, fullTags[i]);
    end
    check("R8 full blocks issue", 32'(issueReady), 32'd0);
    tg = issueTag;
    issueValid = 1'b1;
    issueDest  = 5'd20;
    tick();
    issueValid = 1'b0;
    check("R8 issue ignored when full", 32'(issueTag), 32'(tg));
    for (int i = 15; i >= 0; i--) begin
      doComplete(fullTags[i], 32'h0000_2000 + 32'(i), 1'b0);
    end
    peek(5'd20, v);
    check("R3 youngest result kept", v, 32'h0000_200F);
    repeat (18) tick();
    check("R8 issue reopens after drain", 32'(issueReady), 32'd1);
    peek(5'd20, v);
    check("R4 retire leaves reg20", v, 32'h0000_200F);

    wrapUp();
  end
endmodule